// File: doc/BRIEF.md
# Branch Target Buffer

This block is a direct-mapped, tagged table that fetch logic consults each cycle. It gives the address to fetch after the current program counter. The fetch PC is looked up combinationally. If the indexed entry is valid and its stored tag equals the PC's upper bits exactly, the block reports a hit. It then returns the remembered target address and, when the build option is on, the instruction word found at that target. On a miss, the next fetch address is the sequential one, PC + 4.

Branch resolution logic drives a single update port. A resolved taken branch fills the indexed entry with its tag, target and target instruction, and replaces any earlier occupant. A resolved not-taken branch whose PC matches the resident entry drops that entry. Each entry therefore moves between two conditions:

- EMPTY becomes HELD through a FILL action.
- HELD stays HELD through a FILL action, which may replace the occupant.
- HELD becomes EMPTY through a DROP action.
- Every other update is a NONE action that leaves the entry alone.

Top module: `btb_top`

## Requirements
- R1: After reset every entry is EMPTY, so every lookup misses.
- R2: On a miss, `hit` is 0, `next_pc` is `fetch_pc + 4` and `pred_insn` is 0.
- R3: After a taken update to PC P with target T and word W, a lookup of P from the following cycle on gives `hit`=1, `next_pc`=T and `pred_insn`=W.
- R4: A hit needs the full tag `pc[PC_W-1:IDX_W+2]` to match. A PC that shares the index bits `pc[IDX_W+1:2]` but differs in the tag misses.
- R5: A taken update replaces the occupant of its index, and the previous PC at that index then misses.
- R6: A not-taken update whose PC matches the resident entry drops it, so a later lookup of that PC misses.
- R7: A not-taken update whose tag differs from the resident entry leaves that entry unchanged.
- R8: An update is not forwarded. A lookup in the same cycle as the update to its index sees the old contents.
- R9: PC bits [1:0] take part in neither the index nor the tag. Lookups of P and P+2 give the same result.
- R10: With `upd_en` low the table is unchanged, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | PC being fetched |
| hit | output | 1 | Valid entry with matching tag |
| next_pc | output | PC_W | Predicted target or PC + 4 |
| pred_insn | output | INSN_W | Stored target instruction on a hit, else 0 |
| upd_en | input | 1 | A branch resolved this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Branch was taken |
| upd_target | input | PC_W | Resolved target address |
| upd_insn | input | INSN_W | Instruction word at the target |

## Verification
Lookups are applied in four patterns, each of which separates a different fault:

- A PC just installed versus one that aliases it on the index with a different tag, which shows whether the whole tag is compared.
- A PC versus its half-word offset, which shows whether the low bits are ignored.
- A lookup in the same cycle as a fill versus the cycle after, which shows the absence of forwarding.
- Not-taken updates with matching and non-matching tags, which show that a drop is qualified by the tag, not by the index alone.

A full sweep that fills every index and then reads them all back exposes index decoding faults.

// File: rtl/btb_pkg.sv
package btb_pkg;
    // Action applied to the indexed entry by the update port
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_FILL = 2'd1,
        ACT_DROP = 2'd2
    } upd_act_e;

    // Instructions are word aligned: this many low PC bits are ignored
    localparam int unsigned ALIGN_BITS = 2;
endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int unsigned ENTRIES    = 16,
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned TAG_W      = 26,
    parameter int unsigned PC_W       = 32,
    parameter int unsigned INSN_W     = 32,
    parameter bit          STORE_INSN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [PC_W-1:0]   rd_tgt,
    output logic [INSN_W-1:0] rd_insn,
    input  logic [IDX_W-1:0]  chk_idx,
    output logic              chk_valid,
    output logic [TAG_W-1:0]  chk_tag,
    input  upd_act_e          wr_act,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [PC_W-1:0]   wr_tgt,
    input  logic [INSN_W-1:0] wr_insn
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [PC_W-1:0]    tgt_q [ENTRIES];

    // Valid bits: the per-entry EMPTY/HELD condition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            unique case (wr_act)
                ACT_FILL: valid_q[chk_idx] <= 1'b1;
                ACT_DROP: valid_q[chk_idx] <= 1'b0;
                default:  valid_q <= valid_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_act == ACT_FILL) begin
            tag_q[chk_idx] <= wr_tag;
            tgt_q[chk_idx] <= wr_tgt;
        end
    end

    assign rd_valid  = valid_q[rd_idx];
    assign rd_tag    = tag_q[rd_idx];
    assign rd_tgt    = tgt_q[rd_idx];
    assign chk_valid = valid_q[chk_idx];
    assign chk_tag   = tag_q[chk_idx];

    generate
        if (STORE_INSN) begin : g_insn
            logic [INSN_W-1:0] insn_q [ENTRIES];
            always_ff @(posedge clk) begin
                if (wr_act == ACT_FILL) insn_q[chk_idx] <= wr_insn;
            end
            assign rd_insn = insn_q[rd_idx];
        end else begin : g_no_insn
            assign rd_insn = '0;
        end
    endgenerate
endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
    import btb_pkg::*;
#(
    parameter int unsigned TAG_W = 26
) (
    input  logic             upd_en,
    input  logic             upd_taken,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             res_valid,
    input  logic [TAG_W-1:0] res_tag,
    output upd_act_e         act
);
    logic res_match;
    assign res_match = res_valid && (res_tag == upd_tag);

    always_comb begin
        unique case ({upd_en, upd_taken})
            2'b11:   act = ACT_FILL;
            2'b10:   act = res_match ? ACT_DROP : ACT_NONE;
            default: act = ACT_NONE;
        endcase
    end
endmodule

// File: rtl/btb_match.sv
module btb_match #(
    parameter int unsigned TAG_W  = 26,
    parameter int unsigned PC_W   = 32,
    parameter int unsigned INSN_W = 32
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [TAG_W-1:0]  pc_tag,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [PC_W-1:0]   ent_tgt,
    input  logic [INSN_W-1:0] ent_insn,
    output logic              hit,
    output logic [PC_W-1:0]   next_pc,
    output logic [INSN_W-1:0] pred_insn
);
    localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(4);

    always_comb begin
        hit = ent_valid && (ent_tag == pc_tag);
        if (hit) begin
            next_pc   = ent_tgt;
            pred_insn = ent_insn;
        end else begin
            next_pc   = pc + SEQ_STEP;
            pred_insn = '0;
        end
    end
endmodule

// File: rtl/btb_top.sv
module btb_top
    import btb_pkg::*;
#(
    parameter int unsigned ENTRIES    = 16,
    parameter int unsigned PC_W       = 32,
    parameter int unsigned INSN_W     = 32,
    parameter bit          STORE_INSN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   fetch_pc,
    output logic              hit,
    output logic [PC_W-1:0]   next_pc,
    output logic [INSN_W-1:0] pred_insn,
    input  logic              upd_en,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [PC_W-1:0]   upd_target,
    input  logic [INSN_W-1:0] upd_insn
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);
    localparam int unsigned TAG_LO = IDX_W + ALIGN_BITS;
    localparam int unsigned TAG_W = PC_W - TAG_LO;

    logic [IDX_W-1:0]  f_idx, u_idx;
    logic [TAG_W-1:0]  f_tag, u_tag;
    logic              rd_valid, chk_valid;
    logic [TAG_W-1:0]  rd_tag, chk_tag;
    logic [PC_W-1:0]   rd_tgt;
    logic [INSN_W-1:0] rd_insn;
    upd_act_e          act;

    assign f_idx = fetch_pc[TAG_LO-1:ALIGN_BITS];
    assign f_tag = fetch_pc[PC_W-1:TAG_LO];
    assign u_idx = upd_pc[TAG_LO-1:ALIGN_BITS];
    assign u_tag = upd_pc[PC_W-1:TAG_LO];

    btb_store #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .PC_W(PC_W), .INSN_W(INSN_W), .STORE_INSN(STORE_INSN)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(f_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
        .rd_tgt(rd_tgt), .rd_insn(rd_insn),
        .chk_idx(u_idx), .chk_valid(chk_valid), .chk_tag(chk_tag),
        .wr_act(act), .wr_tag(u_tag), .wr_tgt(upd_target), .wr_insn(upd_insn)
    );

    btb_update_ctl #(.TAG_W(TAG_W)) u_ctl (
        .upd_en(upd_en), .upd_taken(upd_taken), .upd_tag(u_tag),
        .res_valid(chk_valid), .res_tag(chk_tag), .act(act)
    );

    btb_match #(.TAG_W(TAG_W), .PC_W(PC_W), .INSN_W(INSN_W)) u_match (
        .pc(fetch_pc), .pc_tag(f_tag),
        .ent_valid(rd_valid), .ent_tag(rd_tag), .ent_tgt(rd_tgt), .ent_insn(rd_insn),
        .hit(hit), .next_pc(next_pc), .pred_insn(pred_insn)
    );
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
    parameter int unsigned PC_W   = 32,
    parameter int unsigned INSN_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   fetch_pc,
    input logic              hit,
    input logic [PC_W-1:0]   next_pc,
    input logic [INSN_W-1:0] pred_insn,
    input logic              upd_en,
    input logic [PC_W-1:0]   upd_pc,
    input logic              upd_taken,
    input logic [PC_W-1:0]   upd_target
);
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !hit);

    p_miss_sequential_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (next_pc == fetch_pc + PC_W'(4)) && (pred_insn == '0));

    p_fill_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken) |=>
            ((fetch_pc != $past(upd_pc)) || (hit && next_pc == $past(upd_target))));

    p_drop_misses_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken) |=> ((fetch_pc != $past(upd_pc)) || !hit));

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> (!$stable(fetch_pc) || ($stable(hit) && $stable(next_pc))));
endmodule

bind btb_top btb_chk #(.PC_W(PC_W), .INSN_W(INSN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .hit(hit),
    .next_pc(next_pc), .pred_insn(pred_insn), .upd_en(upd_en),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
);

// File: tb/sim_btb_top.sv
module sim_btb_top;
    localparam int CLK_P = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        hit;
    logic [31:0] next_pc;
    logic [31:0] pred_insn;
    logic        upd_en = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic [31:0] upd_insn = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    btb_top u0 (.*);

    typedef struct {
        logic        e_hit;
        logic [31:0] e_next;
        logic [31:0] e_insn;
        string       req;
    } exp_t;
    exp_t sb[$];

    // Reference table built from the requirements
    bit          m_v [N];
    logic [25:0] m_tag [N];
    logic [31:0] m_tgt [N];
    logic [31:0] m_ins [N];

    task automatic cyc(input logic [31:0] fpc, input bit chk, input string req,
                       input bit en = 0, input logic [31:0] upc = 0, input bit tk = 0,
                       input logic [31:0] tgt = 0, input logic [31:0] ins = 0);
        exp_t e;
        int fi;
        int ui;
        @(negedge clk);
        fetch_pc = fpc; upd_en = en; upd_pc = upc; upd_taken = tk;
        upd_target = tgt; upd_insn = ins;
        fi = int'(fpc[5:2]);
        ui = int'(upc[5:2]);
        e.req = req;
        e.e_hit = m_v[fi] && (m_tag[fi] == fpc[31:6]);
        e.e_next = e.e_hit ? m_tgt[fi] : fpc + 32'd4;
        e.e_insn = e.e_hit ? m_ins[fi] : 32'd0;
        if (chk) sb.push_back(e);
        // model update after computing the lookup (R8: no forwarding)
        if (en && tk) begin
            m_v[ui] = 1; m_tag[ui] = upc[31:6]; m_tgt[ui] = tgt; m_ins[ui] = ins;
        end else if (en && m_v[ui] && m_tag[ui] == upc[31:6]) begin
            m_v[ui] = 0;
        end
    endtask

    // Monitor: compares a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (hit !== e.e_hit || next_pc !== e.e_next || pred_insn !== e.e_insn) begin
                    n_bad++;
                    $display("FAIL %s pc=%h got hit=%b next=%h insn=%h exp hit=%b next=%h insn=%h",
                             e.req, fetch_pc, hit, next_pc, pred_insn,
                             e.e_hit, e.e_next, e.e_insn);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 / R2: empty table after reset
        cyc(32'h0000_0100, 1, "R1");
        cyc(32'h0000_0000, 1, "R2");
        // R8: fill and look up in the same cycle sees the old contents
        cyc(32'h0000_1000, 1, "R8", 1, 32'h0000_1000, 1, 32'h0000_2000, 32'hAAAA_5555);
        cyc(32'h0000_1000, 1, "R3");
        cyc(32'h0000_1002, 1, "R9");
        // R4: same index, other tag
        cyc(32'h0000_1040, 1, "R4");
        // R5: replace the occupant
        cyc(32'h0000_1040, 1, "R5", 1, 32'h0000_1040, 1, 32'h0000_3000, 32'h1234_5678);
        cyc(32'h0000_1000, 1, "R5");
        cyc(32'h0000_1040, 1, "R5");
        // R7: not-taken with a mismatched tag leaves the entry
        cyc(32'h0000_1040, 1, "R7", 1, 32'h0000_1000, 0);
        cyc(32'h0000_1040, 1, "R7");
        // R6: not-taken with a matching tag drops it
        cyc(32'h0000_1040, 1, "R6", 1, 32'h0000_1040, 0);
        cyc(32'h0000_1040, 1, "R6");
        // R10: disabled update has no effect
        cyc(32'h0000_1080, 1, "R10", 0, 32'h0000_1080, 1, 32'h0000_4000, 32'hDEAD_BEEF);
        cyc(32'h0000_1080, 1, "R10");
        // Sweep: fill every index, then read all back (R3), then aliases (R4)
        for (int i = 0; i < N; i++)
            cyc(32'h0000_0000, 0, "R3", 1, 32'h0008_0000 + 32'(i*4), 1,
                32'h0010_0000 + 32'(i*16), 32'hC000_0000 + 32'(i));
        for (int i = 0; i < N; i++) cyc(32'h0008_0000 + 32'(i*4), 1, "R3");
        for (int i = 0; i < N; i++) cyc(32'h0009_0000 + 32'(i*4), 1, "R4");
        cyc(32'h0000_0000, 0, "R2");
        cyc(32'h0000_0000, 0, "R2");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule